// File: doc/BRIEF.md
# Header-and-Payload Packet Deparser

This block rebuilds an outgoing packet from two inputs: a record that holds every header a packet might carry, and a payload stream. The record says which headers are present. A link header is always sent. A tag header can be added or left out. The network layer can be version 4, version 6 or absent. The transport layer can be TCP, UDP or absent. The present headers are placed back to back in one fixed order. The payload bytes come straight after them on a wide output bus. The bus carries a byte keep mask and an end-of-packet flag.

Each header combination that can occur has its own fixed concatenation. A per-packet code picks one of these, so no general permutation network is built. A small state machine then sends the header bytes one beat at a time. While it does so, the payload input is held back. When the headers are done, a byte-lane shifter places each payload beat behind the bytes left over from the previous beat. On the last beat, those leftover bytes are first the header tail and then the payload overflow. If the shift pushes the final bytes past a beat boundary, one extra closing beat is sent.

Top module: `hdr_deparser`

## Requirements
- R1: The output byte stream is the present headers in the order link, tag, network, transport, followed at once by every payload byte, with no gap. Stream byte k travels in lane k mod BUS_BYTES, and lane i is bits [8i+7:8i] of `out_data`. Byte j of a header field or of a payload beat is bits [8j+7:8j] of that vector.
- R2: The 4-byte tag header is emitted only when `hdr_vlan_en` is 1. When it is left out, the following headers and the payload move 4 bytes earlier.
- R3: `hdr_l3_sel` value 1 emits the 20-byte IPv4 header and value 2 emits the 40-byte IPv6 header. Values 0 and 3 emit no network header.
- R4: `hdr_l4_sel` value 1 emits the 20-byte TCP header and value 2 emits the 8-byte UDP header. Values 0 and 3 emit nothing. No transport header is emitted when no network header is present.
- R5: `hdr_ready` is 1 only while the block is idle. A header record is taken on a clock edge where `hdr_valid` and `hdr_ready` are both 1. `hdr_ready` then stays 0 until the packet's last output beat has been sent.
- R6: After a record is taken, `pl_ready` stays 0 for exactly floor(H / BUS_BYTES) cycles, where H is the total header length, while the header-only beats go out.
- R7: Every output beat other than the last has all keep bits set. The last beat keeps the lowest ((H+P) mod BUS_BYTES) lanes, where P is the payload length, or all lanes when that value is 0. Payload lanes outside `pl_keep` never reach the output.
- R8: `out_last` is 1 on exactly one beat per packet. The packet takes ceil((H+P)/BUS_BYTES) beats, which includes one extra closing beat when the shifted payload spills past the beat of the last input beat.
- R9: Payload beats must have contiguous keep bits starting at lane 0, and all bits set except on the last beat. Each accepted payload beat then produces an output beat in the next cycle.
- R10: After reset, `out_valid` is 0, `hdr_ready` is 1 and `pl_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header record offered |
| hdr_ready | output | 1 | Header record can be taken |
| hdr_eth | input | 112 | Link header bytes |
| hdr_vlan_en | input | 1 | Insert the tag header |
| hdr_vlan | input | 32 | Tag header bytes |
| hdr_l3_sel | input | 2 | Network header choice |
| hdr_ipv4 | input | 160 | IPv4 header bytes |
| hdr_ipv6 | input | 320 | IPv6 header bytes |
| hdr_l4_sel | input | 2 | Transport header choice |
| hdr_tcp | input | 160 | TCP header bytes |
| hdr_udp | input | 64 | UDP header bytes |
| pl_valid | input | 1 | Payload beat offered |
| pl_ready | output | 1 | Payload beat can be taken |
| pl_data | input | 8*BUS_BYTES | Payload bytes |
| pl_keep | input | BUS_BYTES | Payload byte enables |
| pl_last | input | 1 | Final payload beat |
| out_valid | output | 1 | Output beat present |
| out_data | output | 8*BUS_BYTES | Output bytes |
| out_keep | output | BUS_BYTES | Output byte enables |
| out_last | output | 1 | Final output beat |

## Verification
The bench builds the block with BUS_BYTES = 16 instead of the default 64. A 16-byte bus turns the 14 to 78 byte header range into zero to four header-only beats. It also gives the header tail many residual offsets within a beat: 14, 2, 6, 10 and others. At this width, short payloads reach all three endings: the last beat fits, the last beat fills the bus exactly, and the last beat spills into an extra closing beat. The full set of 32 header code combinations is run, including the invalid codes 3, together with hand-picked exact-fill cases. Lanes outside the payload keep are filled with junk to show that they are masked.

// File: rtl/deparse_pkg.sv
package deparse_pkg;

    localparam int ETH_B     = 14;
    localparam int VLAN_B    = 4;
    localparam int IP4_B     = 20;
    localparam int IP6_B     = 40;
    localparam int TCP_B     = 20;
    localparam int UDP_B     = 8;
    localparam int HDR_MAX_B = ETH_B + VLAN_B + IP6_B + TCP_B;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HDR   = 2'd1,
        ST_PAY   = 2'd2,
        ST_FLUSH = 2'd3
    } dp_state_e;

    function automatic int net_len(input int code);
        return (code == 1) ? IP4_B : (code == 2) ? IP6_B : 0;
    endfunction

    function automatic int xport_len(input int code);
        return (code == 1) ? TCP_B : (code == 2) ? UDP_B : 0;
    endfunction

endpackage

// File: rtl/deparse_hdr_pack.sv
// Builds one fixed concatenation per header combination that can occur
// and selects the one matching the record's presence code.
module deparse_hdr_pack
    import deparse_pkg::*;
#(
    parameter int BUS_BYTES = 64
) (
    input  logic [ETH_B*8-1:0]      eth,
    input  logic                    vlan_en,
    input  logic [VLAN_B*8-1:0]     vlan,
    input  logic [1:0]              l3_sel,
    input  logic [IP4_B*8-1:0]      ipv4,
    input  logic [IP6_B*8-1:0]      ipv6,
    input  logic [1:0]              l4_sel,
    input  logic [TCP_B*8-1:0]      tcp,
    input  logic [UDP_B*8-1:0]      udp,
    output logic [((HDR_MAX_B+BUS_BYTES-1)/BUS_BYTES+1)*BUS_BYTES*8-1:0] hbuf,
    output logic [7:0]              hlen
);
    localparam int HDR_BEATS = (HDR_MAX_B + BUS_BYTES - 1) / BUS_BYTES;
    localparam int BW        = (HDR_BEATS + 1) * BUS_BYTES * 8;
    localparam int SEQS      = 18;

    logic [BW-1:0] cand [SEQS];
    logic [7:0]    clen [SEQS];

    for (genvar gv = 0; gv < 2; gv++) begin : g_tag
        for (genvar g3 = 0; g3 < 3; g3++) begin : g_net
            for (genvar g4 = 0; g4 < 3; g4++) begin : g_xp
                localparam int K = gv * 9 + g3 * 3 + g4;
                if (g3 == 0 && g4 != 0) begin : g_never
                    assign cand[K] = '0;
                    assign clen[K] = '0;
                end else begin : g_seq
                    localparam int OV  = ETH_B;
                    localparam int O3  = OV + gv * VLAN_B;
                    localparam int O4  = O3 + net_len(g3);
                    localparam int TOT = O4 + xport_len(g4);
                    assign cand[K] = BW'(eth)
                        | ((gv == 1) ? (BW'(vlan) << (8 * OV)) : BW'(0))
                        | ((g3 == 1) ? (BW'(ipv4) << (8 * O3)) : BW'(0))
                        | ((g3 == 2) ? (BW'(ipv6) << (8 * O3)) : BW'(0))
                        | ((g4 == 1) ? (BW'(tcp)  << (8 * O4)) : BW'(0))
                        | ((g4 == 2) ? (BW'(udp)  << (8 * O4)) : BW'(0));
                    assign clen[K] = 8'(TOT);
                end
            end
        end
    end

    logic [1:0] l3_n, l4_n;
    logic [4:0] sel;

    always_comb begin
        l3_n = (l3_sel == 2'd3) ? 2'd0 : l3_sel;
        l4_n = (l3_n == 2'd0 || l4_sel == 2'd3) ? 2'd0 : l4_sel;
        sel  = 5'(int'(vlan_en) * 9 + int'(l3_n) * 3 + int'(l4_n));
        hbuf = cand[sel];
        hlen = clen[sel];
    end

endmodule

// File: rtl/deparse_pay_align.sv
// Byte-lane shifter: places a payload beat right after the carried bytes.
module deparse_pay_align #(
    parameter int BUS_BYTES = 64,
    localparam int DW = BUS_BYTES * 8,
    localparam int CW = $clog2(BUS_BYTES + 1)
) (
    input  logic [DW-1:0]        carry,
    input  logic [CW-1:0]        cnt,
    input  logic [DW-1:0]        pl_data,
    input  logic [BUS_BYTES-1:0] pl_keep,
    output logic [2*DW-1:0]      merged,
    output logic [CW:0]          total
);
    logic [DW-1:0]   clean;
    logic [2*DW-1:0] shifted;
    logic [CW:0]     nbytes;

    always_comb begin
        nbytes = '0;
        for (int i = 0; i < BUS_BYTES; i++) begin
            clean[8*i +: 8] = pl_keep[i] ? pl_data[8*i +: 8] : 8'h00;
            nbytes          = nbytes + (CW+1)'(pl_keep[i]);
        end
        shifted = '0;
        for (int j = 0; j < 2 * BUS_BYTES; j++) begin
            for (int s = 0; s <= BUS_BYTES; s++) begin
                if (int'(cnt) == s && j >= s && j - s < BUS_BYTES)
                    shifted[8*j +: 8] = clean[8*(j-s) +: 8];
            end
        end
        merged = (2*DW)'(carry) | shifted;
        total  = (CW+1)'(cnt) + nbytes;
    end

endmodule

// File: rtl/hdr_deparser.sv
module hdr_deparser
    import deparse_pkg::*;
#(
    parameter int BUS_BYTES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hdr_valid,
    output logic                     hdr_ready,
    input  logic [111:0]             hdr_eth,
    input  logic                     hdr_vlan_en,
    input  logic [31:0]              hdr_vlan,
    input  logic [1:0]               hdr_l3_sel,
    input  logic [159:0]             hdr_ipv4,
    input  logic [319:0]             hdr_ipv6,
    input  logic [1:0]               hdr_l4_sel,
    input  logic [159:0]             hdr_tcp,
    input  logic [63:0]              hdr_udp,
    input  logic                     pl_valid,
    output logic                     pl_ready,
    input  logic [BUS_BYTES*8-1:0]   pl_data,
    input  logic [BUS_BYTES-1:0]     pl_keep,
    input  logic                     pl_last,
    output logic                     out_valid,
    output logic [BUS_BYTES*8-1:0]   out_data,
    output logic [BUS_BYTES-1:0]     out_keep,
    output logic                     out_last
);
    localparam int DW        = BUS_BYTES * 8;
    localparam int CW        = $clog2(BUS_BYTES + 1);
    localparam int HDR_BEATS = (HDR_MAX_B + BUS_BYTES - 1) / BUS_BYTES;
    localparam int BUF_W     = (HDR_BEATS + 1) * DW;
    localparam int IW        = $clog2(HDR_BEATS + 1) + 1;

    typedef struct packed {
        dp_state_e          st;
        logic [IW-1:0]      idx;
        logic [IW-1:0]      hbeats;
        logic [BUF_W-1:0]   hbuf;
        logic [DW-1:0]      carry;
        logic [CW-1:0]      cnt;
        logic               ov;
        logic [DW-1:0]      od;
        logic [BUS_BYTES-1:0] ok;
        logic               ol;
    } dp_regs_t;

    dp_regs_t r_d, r_q;

    logic [BUF_W-1:0] pk_hbuf;
    logic [7:0]       pk_hlen;
    logic [2*DW-1:0]  al_merged;
    logic [CW:0]      al_total;

    deparse_hdr_pack #(.BUS_BYTES(BUS_BYTES)) u_pack (
        .eth     (hdr_eth),
        .vlan_en (hdr_vlan_en),
        .vlan    (hdr_vlan),
        .l3_sel  (hdr_l3_sel),
        .ipv4    (hdr_ipv4),
        .ipv6    (hdr_ipv6),
        .l4_sel  (hdr_l4_sel),
        .tcp     (hdr_tcp),
        .udp     (hdr_udp),
        .hbuf    (pk_hbuf),
        .hlen    (pk_hlen)
    );

    deparse_pay_align #(.BUS_BYTES(BUS_BYTES)) u_align (
        .carry   (r_q.carry),
        .cnt     (r_q.cnt),
        .pl_data (pl_data),
        .pl_keep (pl_keep),
        .merged  (al_merged),
        .total   (al_total)
    );

    function automatic logic [BUS_BYTES-1:0] low_lanes(input int k);
        logic [BUS_BYTES-1:0] m;
        for (int i = 0; i < BUS_BYTES; i++) m[i] = (i < k);
        return m;
    endfunction

    assign hdr_ready = (r_q.st == ST_IDLE);
    assign pl_ready  = (r_q.st == ST_PAY);

    always_comb begin
        r_d    = r_q;
        r_d.ov = 1'b0;
        r_d.ol = 1'b0;
        r_d.ok = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (hdr_valid) begin
                    r_d.hbuf   = pk_hbuf;
                    r_d.hbeats = IW'(int'(pk_hlen) / BUS_BYTES);
                    r_d.cnt    = CW'(int'(pk_hlen) % BUS_BYTES);
                    r_d.carry  = pk_hbuf[DW-1:0];
                    r_d.idx    = '0;
                    r_d.st     = (int'(pk_hlen) >= BUS_BYTES) ? ST_HDR : ST_PAY;
                end
            end
            ST_HDR: begin
                r_d.ov    = 1'b1;
                r_d.od    = r_q.hbuf[int'(r_q.idx) * DW +: DW];
                r_d.ok    = '1;
                r_d.carry = r_q.hbuf[(int'(r_q.idx) + 1) * DW +: DW];
                r_d.idx   = r_q.idx + 1'b1;
                if (r_q.idx + 1'b1 == r_q.hbeats) r_d.st = ST_PAY;
            end
            ST_PAY: begin
                if (pl_valid) begin
                    if (int'(al_total) >= BUS_BYTES) begin
                        r_d.ov    = 1'b1;
                        r_d.od    = al_merged[DW-1:0];
                        r_d.ok    = '1;
                        r_d.carry = al_merged[2*DW-1:DW];
                        r_d.cnt   = CW'(int'(al_total) - BUS_BYTES);
                        if (pl_last) begin
                            if (int'(al_total) == BUS_BYTES) begin
                                r_d.ol = 1'b1;
                                r_d.st = ST_IDLE;
                            end else begin
                                r_d.st = ST_FLUSH;
                            end
                        end
                    end else if (pl_last) begin
                        r_d.ov = 1'b1;
                        r_d.od = al_merged[DW-1:0];
                        r_d.ok = low_lanes(int'(al_total));
                        r_d.ol = 1'b1;
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.carry = al_merged[DW-1:0];
                        r_d.cnt   = CW'(al_total);
                    end
                end
            end
            ST_FLUSH: begin
                r_d.ov = 1'b1;
                r_d.od = r_q.carry;
                r_d.ok = low_lanes(int'(r_q.cnt));
                r_d.ol = 1'b1;
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = r_q.ov;
    assign out_data  = r_q.od;
    assign out_keep  = r_q.ok;
    assign out_last  = r_q.ol;

    // R7: kept lanes form a non-empty run from lane 0
    p_keep_contig_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_keep != '0) &&
                      (((out_keep + BUS_BYTES'(1)) & out_keep) == '0));

    // R7: only the closing beat may be partial
    p_full_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> &out_keep);

    // R9: a well-formed accepted payload beat yields an output beat next cycle
    p_beat_per_pay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pl_valid && pl_ready && (pl_last || &pl_keep) |=> out_valid);

    // R5: block is busy right after taking a record
    p_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready |=> !hdr_ready);

    // R8: spilled bytes close the packet on the following beat
    p_flush_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.st == ST_FLUSH |=> out_valid && out_last);

    // R8: after the closing beat the block is ready for a new record
    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> hdr_ready && !pl_ready);

endmodule

// File: tb/hdr_deparser_tb_top.sv
`timescale 1ns/1ps
module hdr_deparser_tb_top;
    localparam int BB = 16;
    localparam int DW = BB * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic           hdr_valid = 1'b0;
    logic           hdr_ready;
    logic [111:0]   hdr_eth = '0;
    logic           hdr_vlan_en = 1'b0;
    logic [31:0]    hdr_vlan = '0;
    logic [1:0]     hdr_l3_sel = '0;
    logic [159:0]   hdr_ipv4 = '0;
    logic [319:0]   hdr_ipv6 = '0;
    logic [1:0]     hdr_l4_sel = '0;
    logic [159:0]   hdr_tcp = '0;
    logic [63:0]    hdr_udp = '0;
    logic           pl_valid = 1'b0;
    logic           pl_ready;
    logic [DW-1:0]  pl_data = '0;
    logic [BB-1:0]  pl_keep = '0;
    logic           pl_last = 1'b0;
    logic           out_valid;
    logic [DW-1:0]  out_data;
    logic [BB-1:0]  out_keep;
    logic           out_last;

    hdr_deparser #(.BUS_BYTES(BB)) dut_i (.*);

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] q_data [$];
    logic [BB-1:0] q_keep [$];
    logic          q_last [$];

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_data.size() == 0) begin
                chk(1'b0, "R8 unexpected output beat", DW'(out_last), '0);
            end else begin
                logic [DW-1:0] ed, m;
                logic [BB-1:0] ek;
                logic          el;
                ed = q_data.pop_front();
                ek = q_keep.pop_front();
                el = q_last.pop_front();
                m = '0;
                for (int i = 0; i < BB; i++) if (ek[i]) m[8*i +: 8] = 8'hFF;
                chk((out_data & m) == ed, "R1/R2/R3/R4 beat bytes", out_data & m, ed);
                chk(out_keep == ek, "R7 keep mask", DW'(out_keep), DW'(ek));
                chk(out_last == el, "R8 last flag", DW'(out_last), DW'(el));
            end
        end
    end

    task automatic send_pkt(input int vl, input int l3, input int l4,
                            input int plen, input int seed);
        logic [7:0] s [$];
        int hlen, nb, pbeats, hwait;
        s = {};
        for (int j = 0; j < 14; j++) begin
            hdr_eth[8*j +: 8] = 8'(seed + j); s.push_back(8'(seed + j));
        end
        for (int j = 0; j < 4; j++) begin
            hdr_vlan[8*j +: 8] = 8'(seed + 40 + j);
            if (vl != 0) s.push_back(8'(seed + 40 + j));
        end
        for (int j = 0; j < 20; j++) begin
            hdr_ipv4[8*j +: 8] = 8'(seed + 60 + j);
            if (l3 == 1) s.push_back(8'(seed + 60 + j));
        end
        for (int j = 0; j < 40; j++) begin
            hdr_ipv6[8*j +: 8] = 8'(seed + 90 + j);
            if (l3 == 2) s.push_back(8'(seed + 90 + j));
        end
        for (int j = 0; j < 20; j++) begin
            hdr_tcp[8*j +: 8] = 8'(seed + 140 + j);
            if ((l3 == 1 || l3 == 2) && l4 == 1) s.push_back(8'(seed + 140 + j));
        end
        for (int j = 0; j < 8; j++) begin
            hdr_udp[8*j +: 8] = 8'(seed + 170 + j);
            if ((l3 == 1 || l3 == 2) && l4 == 2) s.push_back(8'(seed + 170 + j));
        end
        hlen = s.size();
        for (int k = 0; k < plen; k++) s.push_back(8'(seed * 3 + k + 128));
        nb = (s.size() + BB - 1) / BB;
        for (int b = 0; b < nb; b++) begin
            logic [DW-1:0] d;
            logic [BB-1:0] kp;
            d = '0; kp = '0;
            for (int i = 0; i < BB; i++) begin
                if (b * BB + i < s.size()) begin
                    d[8*i +: 8] = s[b * BB + i]; kp[i] = 1'b1;
                end
            end
            q_data.push_back(d); q_keep.push_back(kp); q_last.push_back(b == nb - 1);
        end

        @(negedge clk);
        hdr_vlan_en = (vl != 0);
        hdr_l3_sel  = 2'(l3);
        hdr_l4_sel  = 2'(l4);
        hdr_valid   = 1'b1;
        while (!hdr_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        hdr_valid = 1'b0;
        chk(!hdr_ready, "R5 busy after record taken", DW'(hdr_ready), '0);
        hwait = 0;
        while (!pl_ready) begin hwait++; @(negedge clk); end
        chk(hwait == hlen / BB, "R6 payload hold cycles", DW'(hwait), DW'(hlen / BB));

        pbeats = (plen + BB - 1) / BB;
        for (int b = 0; b < pbeats; b++) begin
            pl_valid = 1'b1;
            pl_last  = (b == pbeats - 1);
            pl_data  = '0;
            pl_keep  = '0;
            for (int i = 0; i < BB; i++) begin
                if (b * BB + i < plen) begin
                    pl_data[8*i +: 8] = 8'(seed * 3 + b * BB + i + 128);
                    pl_keep[i] = 1'b1;
                end else begin
                    pl_data[8*i +: 8] = 8'hEE;   // junk outside keep (R7)
                end
            end
            @(posedge clk);
            @(negedge clk);
            chk(out_valid, "R9 output beat follows payload beat", DW'(out_valid), 1);
        end
        pl_valid = 1'b0;
        pl_last  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid, "R10 reset out_valid", DW'(out_valid), 0);
        chk(hdr_ready,  "R10 reset hdr_ready", DW'(hdr_ready), 1);
        chk(!pl_ready,  "R10 reset pl_ready",  DW'(pl_ready), 0);

        seed = 1;
        for (int v = 0; v < 2; v++)
            for (int a = 0; a < 4; a++)
                for (int t = 0; t < 4; t++) begin
                    send_pkt(v, a, t, 1 + (seed * 7) % 45, seed);
                    seed++;
                end
        // exact fills of the closing beat (R7 all-ones last keep, R8 no extra beat)
        send_pkt(0, 1, 2, 6, 50);    // 42 + 6 = 48
        send_pkt(0, 0, 0, 2, 51);    // 14 + 2 = 16
        send_pkt(1, 2, 1, 16, 52);   // 78 + 16 = 94, spill case
        send_pkt(0, 2, 2, 18, 53);   // 62 + 18 = 80
        send_pkt(1, 1, 0, 30, 54);   // 38 + 30 = 68, extra beat

        repeat (5) @(negedge clk);
        chk(q_data.size() == 0, "R8 all expected beats produced",
            DW'(q_data.size()), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R8 watchdog expired actual=%0d expected=0", q_data.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule